// File: doc/BRIEF.md
# Battery Charge Enable Controller

This block decides when a battery charger may be connected. It watches two comparator flags that arrive without a clock: one reports that the battery has sagged below its lower threshold, the other that the battery is still under its upper, harmful threshold (so charging is permitted). Both flags pass through two-flop synchronizers. A set/reset latch holds a single charge-enable output.

Turn-on is slow and qualified. Both the "below low" and the "permitted" flags must hold together for a programmable number of clock cycles before the latch sets. If the qualified request breaks before that count finishes, the count starts again from zero. Turn-off is fast. Once the permitted flag clears, the latch resets on the next edge after synchronization, with no extra delay. Because the set request includes the permitted flag, set and reset can never reach the latch together. This keeps the output from chattering around the upper threshold.

Two instances with different delays can drive two charge sources on one battery. The source that should engage first gets the shorter delay. All pins are plain control and status signals, so there is no stream interface and no back-pressure.

Top module: `charge_enable_ctrl`

## Requirements
- R1: After reset, `charge_en_o` is 0, `state_o` reads idle, and the delay count is cleared, so a full delay is needed before the first turn-on.
- R2: Each input goes through two synchronizing flops, so a change on an input reaches the decision logic on the second rising edge after it is applied.
- R3: When both inputs rise together and stay high, `charge_en_o` goes to 1 on rising edge DELAY_CYCLES+2 after they were applied, and not before.
- R4: If the qualified request (both inputs high) drops before the delay finishes, the count restarts, and a later request again needs the full DELAY_CYCLES+2 edges.
- R5: When `batt_ok_i` falls, `charge_en_o` is 0 after the third rising edge, whatever the other input or the count is doing.
- R6: `batt_low_i` alone, or `batt_ok_i` alone, never sets `charge_en_o`, however long it is held.
- R7: Once charging, `charge_en_o` stays 1 after `batt_low_i` clears, for as long as `batt_ok_i` stays high.
- R8: `state_o` encodes 0 = idle, 1 = waiting out the delay (qualified request present, not yet charging), 2 = charging. The value 3 never appears.
- R9: Set and reset never reach the latch in the same cycle. A cut-off whose synchronized value arrives on or before the edge where the count would finish stops the turn-on completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| batt_low_i | input | 1 | Battery below lower threshold (asynchronous) |
| batt_ok_i | input | 1 | Battery below upper threshold, charging permitted (asynchronous) |
| charge_en_o | output | 1 | Charger connect enable |
| state_o | output | 2 | 0 idle, 1 waiting, 2 charging |

## Verification
Two events can meet in one cycle: the delay count reaching its end and the permitted flag being withdrawn. To provoke this, the bench raises both inputs and then pulls the permitted flag low DELAY_CYCLES-1 edges later. Its synchronized value then falls on the very edge where the count would complete. The bench passes this case only if the enable never rises. Separate cases check the exact cut-off latency and the count restart when the request is broken partway through.

// File: rtl/cec_pkg.sv
package cec_pkg;
  typedef enum logic [1:0] {
    CEC_IDLE   = 2'd0,
    CEC_WAIT   = 2'd1,
    CEC_CHARGE = 2'd2
  } cec_state_e;
endpackage

// File: rtl/cec_sync.sv
module cec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gs;
  generate
    for (gs = 0; gs < STAGES; gs++) begin : g_stage
      if (gs == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[gs] <= '0;
          else        stage_q[gs] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[gs] <= '0;
          else        stage_q[gs] <= stage_q[gs-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cec_delay.sv
module cec_delay #(
  parameter int DELAY_CYCLES = 64,
  localparam int CW = $clog2(DELAY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual_i,
  output logic fire_o
);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYCLES - 1);
  localparam logic [CW-1:0] TOP  = CW'(DELAY_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cnt_q <= '0;
    else if (!qual_i)   cnt_q <= '0;
    else if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;

  assign fire_o = qual_i && (cnt_q == LAST);

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qual_i |=> (cnt_q == '0));
endmodule

// File: rtl/cec_latch.sv
module cec_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;

  // R9
  no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));
  // R5
  cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
endmodule

// File: rtl/charge_enable_ctrl.sv
module charge_enable_ctrl
  import cec_pkg::*;
#(
  parameter int DELAY_CYCLES = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       batt_low_i,
  input  logic       batt_ok_i,
  output logic       charge_en_o,
  output logic [1:0] state_o
);
  logic [1:0] raw, synced;
  logic       low_s, ok_s, qual, fire;
  cec_state_e st;

  assign raw = {batt_ok_i, batt_low_i};

  cec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced));

  assign low_s = synced[0];
  assign ok_s  = synced[1];
  assign qual  = low_s && ok_s;

  cec_delay #(.DELAY_CYCLES(DELAY_CYCLES)) u_delay (
    .clk(clk), .rst_n(rst_n), .qual_i(qual), .fire_o(fire));

  cec_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(fire), .clr_i(!ok_s), .q_o(charge_en_o));

  always_comb begin
    if (charge_en_o) st = CEC_CHARGE;
    else if (qual)   st = CEC_WAIT;
    else             st = CEC_IDLE;
  end
  assign state_o = st;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (charge_en_o && ok_s) |=> charge_en_o);
  // R3
  rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(charge_en_o) |-> $past(qual));
  // R8
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd3);
endmodule

// File: tb/sim_charge_enable_ctrl.sv
module sim_charge_enable_ctrl;
  localparam int D = 12;
  logic clk = 0, rst_n = 0, low = 0, ok = 0;
  logic en;
  logic [1:0] st;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  charge_enable_ctrl #(.DELAY_CYCLES(D)) u0 (
    .clk(clk), .rst_n(rst_n), .batt_low_i(low), .batt_ok_i(ok),
    .charge_en_o(en), .state_o(st));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    low = 0; ok = 0; tick(5);
  endtask

  task automatic t_reset();
    chk(en == 0, "R1 en", en, 0);
    chk(st == 0, "R1 state", st, 0);
  endtask

  task automatic t_turn_on();
    bit early = 0;
    low = 1; ok = 1;
    tick(1);
    chk(st == 0, "R2 state after one edge", st, 0);
    tick(1);
    chk(st == 1, "R8 waiting", st, 1);
    for (int k = 3; k <= D + 1; k++) begin tick(1); if (en) early = 1; end
    chk(!early, "R3 no early enable", early, 0);
    tick(1);
    chk(en == 1, "R3 enable at DELAY+2", en, 1);
    chk(st == 2, "R8 charging", st, 2);
  endtask

  task automatic t_hold();
    low = 0; tick(6);
    chk(en == 1, "R7 held after low clears", en, 1);
    chk(st == 2, "R7 state charging", st, 2);
  endtask

  task automatic t_cut();
    ok = 0; tick(2);
    chk(en == 1, "R5 still on after two edges", en, 1);
    tick(1);
    chk(en == 0, "R5 off after third edge", en, 0);
    chk(st == 0, "R8 idle after cut", st, 0);
  endtask

  task automatic t_restart();
    bit early = 0;
    low = 1; ok = 1; tick(5);
    low = 0; tick(3);
    chk(en == 0, "R4 no enable after break", en, 0);
    low = 1;
    for (int k = 1; k <= D + 1; k++) begin tick(1); if (en) early = 1; end
    chk(!early, "R4 full delay after restart", early, 0);
    tick(1);
    chk(en == 1, "R4 enable after full delay", en, 1);
    settle();
  endtask

  task automatic t_single();
    bit seen = 0;
    low = 1; ok = 0;
    for (int k = 0; k < 3 * D; k++) begin tick(1); if (en || st != 0) seen = 1; end
    chk(!seen, "R6 low alone", seen, 0);
    settle();
    seen = 0; low = 0; ok = 1;
    for (int k = 0; k < 3 * D; k++) begin tick(1); if (en || st != 0) seen = 1; end
    chk(!seen, "R6 permitted alone", seen, 0);
    settle();
  endtask

  task automatic t_collide();
    bit seen = 0;
    low = 1; ok = 1; tick(D - 1);
    ok = 0;
    for (int k = 0; k < 2 * D; k++) begin tick(1); if (en) seen = 1; end
    chk(!seen, "R9 cut-off wins at delay end", seen, 0);
    settle();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(2);
    t_reset();
    t_turn_on();
    t_hold();
    t_cut();
    settle();
    t_restart();
    t_single();
    t_collide();
    t_turn_on();
    t_cut();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule